// File: doc/BRIEF.md
# Serial Offset Register Loader

This block holds the almost-empty and almost-full threshold offsets of a FIFO and lets them be rewritten one bit at a time through a single serial data pin. That same pin has a second job: while master reset is held, its level is captured as the read-mode strap that picks between standard and fall-through reads. Once reset is released, the pin carries serial data. A second strap input, also captured during reset, decides whether serial programming is allowed at all.

A bit is taken in on a rising edge of the serial clock only if two conditions hold: both active-low strobes, the serial enable and the load strobe, are low, and the serial method was strapped at reset. The bits fill the almost-empty offset first and then the almost-full offset, least significant bit first in each. Once the last almost-full bit is in, the position wraps back to the first almost-empty bit and a one-cycle done pulse is raised. Master reset is sampled on the serial clock. It restores the default offsets and returns the bit position to zero. Both offsets are always visible as parallel outputs.

Top module: `offset_serial_loader`

## Requirements
- R1: While master reset is low at a rising clock edge, the almost-empty offset takes AE_DEFAULT, the almost-full offset takes AF_DEFAULT, the done output goes low, and the bit position returns to zero, so the next accepted bit lands in bit 0 of the almost-empty offset.
- R2: On each clock edge with master reset low, the fall-through strap output takes the level of the shared serial pin, and the serial-method strap takes the level of the serial-select input. Both keep their values until the next reset.
- R3: A rising edge with serial enable low, load strobe low and the serial strap set writes the shared pin level into exactly one offset bit and advances the bit position by one.
- R4: If the serial enable is high or the load strobe is high at an edge, both offsets and the bit position stay as they were.
- R5: The bit position order is almost-empty bits 0 to W-1, then almost-full bits 0 to W-1.
- R6: After almost-full bit W-1 is written, the next accepted bit goes to almost-empty bit 0.
- R7: The done output is high for exactly the one cycle that follows the edge that wrote almost-full bit W-1. It is low at all other times.
- R8: If the serial strap was low at reset, no edge changes either offset or the bit position.
- R9: Serial loading behaves the same whichever level the fall-through strap holds.
- R10: A partial load changes only the bits it reaches. All other offset bits keep their earlier values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock, rising-edge active |
| mrstN | input | 1 | Master reset, active low, sampled on clk |
| sharedIn | input | 1 | Read-mode strap during reset, serial data afterwards |
| serialSel | input | 1 | Serial-method strap, captured during reset |
| serEnN | input | 1 | Serial enable, active low |
| loadN | input | 1 | Load strobe, active low |
| aeOffset | output | W | Almost-empty offset |
| afOffset | output | W | Almost-full offset |
| fallThrough | output | 1 | Captured read-mode strap |
| loadDone | output | 1 | One-cycle pulse after a complete offset pair is in |

## Verification
The hardest case to reach is a wrap that falls in the middle of a stream. There the bit after a full pair must overwrite almost-empty bit 0, and done must not fire again until another full pair has gone through. The stimulus sweeps every possible pair value with a small width under both read-mode straps. It then shifts extra bits past the wrap, interleaves gated edges where only one strobe is low, and finally repeats the stream with the serial strap cleared so that nothing may move.

// File: rtl/offset_ldr_pkg.sv
package offset_ldr_pkg;
  typedef struct packed {
    logic clearAll;  // master reset: load defaults
    logic shiftEn;   // write one serial bit at the current position
  } ldrStrobes_t;
endpackage

// File: rtl/offset_ldr_ctrl.sv
module offset_ldr_ctrl
  import offset_ldr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                         clk,
  input  logic                         mrstN,
  input  logic                         sharedIn,
  input  logic                         serialSel,
  input  logic                         serEnN,
  input  logic                         loadN,
  output ldrStrobes_t                  strobes,
  output logic [$clog2(2*W)-1:0]       bitIdx,
  output logic                         fallThrough,
  output logic                         loadDone
);
  localparam int TOTAL = 2 * W;
  localparam int IDX_W = $clog2(TOTAL);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(TOTAL - 1);

  logic serialMode;
  logic lastBit;

  assign strobes.clearAll = !mrstN;
  assign strobes.shiftEn  = mrstN && serialMode && !serEnN && !loadN;
  assign lastBit          = (bitIdx == LAST);

  always_ff @(posedge clk) begin
    if (!mrstN) begin
      serialMode  <= serialSel;
      fallThrough <= sharedIn;
      bitIdx      <= '0;
      loadDone    <= 1'b0;
    end else begin
      loadDone <= strobes.shiftEn && lastBit;
      if (strobes.shiftEn) begin
        bitIdx <= lastBit ? '0 : bitIdx + 1'b1;
      end
    end
  end

  AST_IDX_WRAP: assert property (@(posedge clk) disable iff (!mrstN)
    (strobes.shiftEn && lastBit) |=> (bitIdx == '0)); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!mrstN)
    loadDone |=> !loadDone); // R7
  AST_NO_SERIAL_FROZEN: assert property (@(posedge clk) disable iff (!mrstN)
    !serialMode |=> $stable(bitIdx)); // R8
  AST_STRAP_HELD: assert property (@(posedge clk) disable iff (!mrstN)
    mrstN |=> ($stable(serialMode) && $stable(fallThrough))); // R2
  AST_IDX_IDLE: assert property (@(posedge clk) disable iff (!mrstN)
    (serEnN || loadN) |=> $stable(bitIdx)); // R4
endmodule

// File: rtl/offset_ldr_datapath.sv
module offset_ldr_datapath
  import offset_ldr_pkg::*;
#(
  parameter int          W          = 8,
  parameter logic [W-1:0] AE_DEFAULT = '0,
  parameter logic [W-1:0] AF_DEFAULT = '0
) (
  input  logic                   clk,
  input  ldrStrobes_t            strobes,
  input  logic [$clog2(2*W)-1:0] bitIdx,
  input  logic                   serIn,
  output logic [W-1:0]           aeOffset,
  output logic [W-1:0]           afOffset
);
  // Almost-empty in the low half so the bit index follows the load order.
  logic [2*W-1:0] pairReg;

  always_ff @(posedge clk) begin
    if (strobes.clearAll) begin
      pairReg <= {AF_DEFAULT, AE_DEFAULT};
    end else if (strobes.shiftEn) begin
      pairReg[bitIdx] <= serIn;
    end
  end

  assign aeOffset = pairReg[W-1:0];
  assign afOffset = pairReg[2*W-1:W];

  AST_ONE_BIT: assert property (@(posedge clk) disable iff (strobes.clearAll)
    strobes.shiftEn |=> ($countones(pairReg ^ $past(pairReg)) <= 1)); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (strobes.clearAll)
    !strobes.shiftEn |=> $stable(pairReg)); // R4
endmodule

// File: rtl/offset_serial_loader.sv
module offset_serial_loader
  import offset_ldr_pkg::*;
#(
  parameter int           W          = 8,
  parameter logic [W-1:0] AE_DEFAULT = W'(7),
  parameter logic [W-1:0] AF_DEFAULT = W'(7)
) (
  input  logic         clk,
  input  logic         mrstN,
  input  logic         sharedIn,
  input  logic         serialSel,
  input  logic         serEnN,
  input  logic         loadN,
  output logic [W-1:0] aeOffset,
  output logic [W-1:0] afOffset,
  output logic         fallThrough,
  output logic         loadDone
);
  localparam int IDX_W = $clog2(2 * W);

  ldrStrobes_t      strobes;
  logic [IDX_W-1:0] bitIdx;

  offset_ldr_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .mrstN(mrstN), .sharedIn(sharedIn), .serialSel(serialSel),
    .serEnN(serEnN), .loadN(loadN), .strobes(strobes), .bitIdx(bitIdx),
    .fallThrough(fallThrough), .loadDone(loadDone)
  );

  offset_ldr_datapath #(.W(W), .AE_DEFAULT(AE_DEFAULT), .AF_DEFAULT(AF_DEFAULT)) u_dp (
    .clk(clk), .strobes(strobes), .bitIdx(bitIdx), .serIn(sharedIn),
    .aeOffset(aeOffset), .afOffset(afOffset)
  );

  AST_RESET_DEFAULTS: assert property (@(posedge clk)
    !mrstN |=> (aeOffset == AE_DEFAULT && afOffset == AF_DEFAULT && !loadDone)); // R1
endmodule

// File: tb/offset_serial_loader_bench.sv
module offset_serial_loader_bench;
  localparam int W = 4;
  localparam int TOTAL = 2 * W;
  localparam logic [W-1:0] AE_D = 4'h3;
  localparam logic [W-1:0] AF_D = 4'hC;

  logic clk = 1'b0;
  logic mrstN = 1'b0, sharedIn = 1'b0, serialSel = 1'b1, serEnN = 1'b1, loadN = 1'b1;
  logic [W-1:0] aeOffset, afOffset;
  logic fallThrough, loadDone;

  int nChecks = 0, nFails = 0;
  logic [W-1:0] expAe, expAf;
  int expIdx;
  logic expSel;

  always #10 clk = ~clk;

  offset_serial_loader #(.W(W), .AE_DEFAULT(AE_D), .AF_DEFAULT(AF_D)) u_offset_serial_loader (
    .clk(clk), .mrstN(mrstN), .sharedIn(sharedIn), .serialSel(serialSel),
    .serEnN(serEnN), .loadN(loadN), .aeOffset(aeOffset), .afOffset(afOffset),
    .fallThrough(fallThrough), .loadDone(loadDone)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doReset(logic ft, logic sel);
    @(negedge clk);
    mrstN = 1'b0; sharedIn = ft; serialSel = sel; serEnN = 1'b1; loadN = 1'b1;
    @(posedge clk);
    @(negedge clk);
    mrstN = 1'b1; sharedIn = 1'b0;
    expAe = AE_D; expAf = AF_D; expIdx = 0; expSel = sel;
    chk("R1 ae", 32'(aeOffset), 32'(AE_D));
    chk("R1 af", 32'(afOffset), 32'(AF_D));
    chk("R1 done", 32'(loadDone), 0);
    chk("R2 strap", 32'(fallThrough), 32'(ft));
  endtask

  // Drive at a falling edge, let one rising edge pass, check at the next falling edge.
  task automatic shiftBit(logic b, logic en, logic ld, string req);
    logic expDone;
    sharedIn = b; serEnN = en; loadN = ld;
    @(posedge clk);
    @(negedge clk);
    serEnN = 1'b1; loadN = 1'b1;
    expDone = 1'b0;
    if (expSel && !en && !ld) begin
      if (expIdx < W) expAe[expIdx] = b;
      else expAf[expIdx - W] = b;
      expDone = (expIdx == TOTAL - 1);
      expIdx = (expIdx + 1) % TOTAL;
    end
    chk({req, " ae"}, 32'(aeOffset), 32'(expAe));
    chk({req, " af"}, 32'(afOffset), 32'(expAf));
    chk({"R7 done/", req}, 32'(loadDone), 32'(expDone));
  endtask

  initial begin
    #(20 * 150000);
    nFails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    // R5 R9: every pair value under both read-mode straps
    for (int ft = 0; ft < 2; ft++) begin
      for (int v = 0; v < (1 << TOTAL); v++) begin
        doReset(ft[0], 1'b1);
        for (int k = 0; k < TOTAL; k++) shiftBit(v[k], 1'b0, 1'b0, "R5");
        chk("R9 ae value", 32'(aeOffset), 32'(v & ((1 << W) - 1)));
        chk("R9 af value", 32'(afOffset), 32'(v >> W));
      end
    end
    // R4: gated edges interleaved; R3: single bit per edge
    doReset(1'b0, 1'b1);
    for (int k = 0; k < 3 * TOTAL; k++) begin
      shiftBit(~expAe[0], 1'b1, 1'b0, "R4 enable high");
      shiftBit(~expAe[0], 1'b0, 1'b1, "R4 load high");
      shiftBit(k[0] ^ k[2], 1'b0, 1'b0, "R3");
    end
    // R6: wrap then partial; R10: partial load keeps the rest
    doReset(1'b1, 1'b1);
    for (int k = 0; k < TOTAL; k++) shiftBit(1'b1, 1'b0, 1'b0, "R6 fill");
    shiftBit(1'b0, 1'b0, 1'b0, "R6 wrap");
    chk("R6 ae bit0", 32'(aeOffset), 32'hE);
    shiftBit(1'b0, 1'b0, 1'b0, "R10 partial");
    chk("R10 rest kept", 32'(afOffset), 32'hF);
    // R8: serial strap low freezes everything
    doReset(1'b0, 1'b0);
    for (int k = 0; k < 2 * TOTAL; k++) shiftBit(~k[0], 1'b0, 1'b0, "R8");
    chk("R8 ae", 32'(aeOffset), 32'(AE_D));
    // R1: reset mid-stream restarts at bit 0
    doReset(1'b0, 1'b1);
    shiftBit(1'b0, 1'b0, 1'b0, "R1 midstream");
    shiftBit(1'b1, 1'b0, 1'b0, "R1 midstream");
    doReset(1'b1, 1'b1);
    shiftBit(1'b0, 1'b0, 1'b0, "R1 restart");
    chk("R1 restart ae", 32'(aeOffset), 32'h2);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule